// File: doc/BRIEF.md
# LCD pixel output packer

This block sits between the pixel-processing pipeline of an LCD controller and the 24-bit data pins of the panel. It takes processed pixel data and lays it out on the pins according to the panel type the controller is set for. A TFT panel gets one full-colour pixel per output word. A passive STN panel gets a serial bit stream that is cut into interface-wide words. A monochrome STN panel takes one bit per input step, and a colour STN panel takes one red, green and blue sub-pixel triple per input step. In dual scan mode the interface is split in half: the upper half carries the upper panel, the lower half carries the lower panel, and each half is fed by its own input stream.

Both input streams use valid/ready handshakes. A transfer happens on a rising clock edge when valid and ready are both high. Once a source raises valid, it must hold valid and data until the transfer happens. The block lowers ready while a lane holds a full word that it has not yet emitted, and also for one cycle after any configuration change. In dual scan mode the two streams advance in lock-step: each stream's ready also requires the other stream's valid, so both transfers always fall on the same edge. The output side has no back-pressure. Each finished word is presented with a one-cycle strobe, and the bus holds its last value between strobes. A configuration that the panel interface cannot support raises an error flag, holds the bus at zero and stalls both inputs.

Configuration encodings: the display type is 0 for TFT, 1 for STN monochrome, 2 for STN colour and 3 reserved. Scan mode is 0 for single and 1 for dual. The STN width code is 0 for 4 bits, 1 for 8 bits, 2 for 16 bits and 3 reserved.

Top module: `lcd_pix_packer`

## Requirements
- R1: `cfg_err` is high exactly when the configuration is illegal. Illegal means display type 3, TFT with dual scan, STN with width code 3, STN 4-bit with dual scan, or STN 16-bit with single scan. The width code is ignored for TFT.
- R2: While `cfg_err` is high, `up_ready` and `lo_ready` are low. From the next cycle on, `lcd_data` is zero and `lcd_strobe` stays low.
- R3: In TFT mode `up_ready` is high. Each accepted `up_data` word appears unchanged on `lcd_data[23:0]` (red in [23:16], green in [15:8], blue in [7:0]) in the cycle after acceptance, with `lcd_strobe` high.
- R4: In STN monochrome mode each transfer contributes `up_data[0]` as one bit. In single scan of width W, the first bit of each word lands on `lcd_data[W-1]` and later bits fill downward. Bits above the interface width are zero.
- R5: In STN colour mode each transfer contributes three bits, taken in the order red `up_data[2]`, green `up_data[1]`, blue `up_data[0]`. The bit stream R0,G0,B0,R1,G1,B1,... fills words MSB-first, so the first 4-bit word is R0,G0,B0,R1 on bits 3 down to 0.
- R6: In dual scan with total width W, the upper stream fills `lcd_data[W-1:W/2]` and the lower stream fills `lcd_data[W/2-1:0]`, each half MSB-first. This gives 4+4 bits for 8-bit and 8+8 bits for 16-bit.
- R7: In dual scan a transfer on one stream always coincides with a transfer on the other stream. A stream whose partner is not valid sees ready low.
- R8: In single scan and TFT modes `lo_ready` is low and `lo_data` has no effect on the output.
- R9: `lcd_strobe` pulses high for exactly one cycle per completed word. After N STN steps, floor(N*bits-per-step/lane-width) words have been strobed.
- R10: A configuration change discards partially packed bits. The first word after the change contains only bits accepted after it.
- R11: When a lane holds a full word, `up_ready` is low until that word has been strobed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_disp | input | 2 | Display type: 0 TFT, 1 STN mono, 2 STN colour |
| cfg_dual | input | 1 | 1 selects dual scan |
| cfg_width | input | 2 | STN width: 0 = 4, 1 = 8, 2 = 16 bits |
| up_valid | input | 1 | Upper/single stream valid |
| up_ready | output | 1 | Upper/single stream ready |
| up_data | input | 24 | Upper/single stream pixel |
| lo_valid | input | 1 | Lower panel stream valid |
| lo_ready | output | 1 | Lower panel stream ready |
| lo_data | input | 24 | Lower panel stream pixel |
| lcd_data | output | 24 | Packed LCD data bus |
| lcd_strobe | output | 1 | One-cycle marker of a new word |
| cfg_err | output | 1 | Illegal configuration flag |

## Verification
The assertions assume that the sources obey the handshake: valid and data are held steady until accepted. They also assume that configuration changes only while no transfer is pending, because a word cut short by a change is deliberately lost. The bench drives every input from the falling edge. It checks ready just before the rising edge and releases valid only after a transfer. It alters the configuration only between streams and waits a few idle cycles afterwards. In dual scan it sometimes raises the upper valid a cycle before the lower valid, which exercises the lock-step rule without ever breaking the hold-until-accepted rule.

// File: rtl/lcd_pack_pkg.sv
package lcd_pack_pkg;
  typedef enum logic [1:0] {
    DISP_TFT   = 2'd0,
    DISP_MONO  = 2'd1,
    DISP_COLOR = 2'd2,
    DISP_RSVD  = 2'd3
  } disp_e;

  typedef enum logic [1:0] {
    IFW_4    = 2'd0,
    IFW_8    = 2'd1,
    IFW_16   = 2'd2,
    IFW_RSVD = 2'd3
  } ifw_e;

  typedef struct packed {
    logic legal;
    logic tft;
    logic color;
    logic dual;
    logic narrow;  // lane carries half of the maximum lane width
  } cfg_dec_t;
endpackage

// File: rtl/lcd_cfg_decode.sv
module lcd_cfg_decode
  import lcd_pack_pkg::*;
(
  input  logic [1:0] disp,
  input  logic       dual,
  input  logic [1:0] width,
  output cfg_dec_t   dec
);
  disp_e d;
  ifw_e  w;
  logic  stn_ok;

  always_comb begin
    d = disp_e'(disp);
    w = ifw_e'(width);
    unique case (w)
      IFW_4:   stn_ok = !dual;
      IFW_8:   stn_ok = 1'b1;
      IFW_16:  stn_ok = dual;
      default: stn_ok = 1'b0;
    endcase
    dec.tft    = (d == DISP_TFT);
    dec.color  = (d == DISP_COLOR);
    dec.dual   = dual;
    dec.narrow = (w == IFW_4) || (w == IFW_8 && dual);
    unique case (d)
      DISP_TFT:   dec.legal = !dual;
      DISP_MONO,
      DISP_COLOR: dec.legal = stn_ok;
      default:    dec.legal = 1'b0;
    endcase
  end
endmodule

// File: rtl/lcd_lane_packer.sv
module lcd_lane_packer #(
  parameter int LANE_MAX = 8,
  parameter int IN_MAX   = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                flush,
  input  logic                narrow,
  input  logic                wide_in,
  input  logic                fire,
  input  logic [IN_MAX-1:0]   bits,
  input  logic                pop,
  output logic                free,
  output logic [LANE_MAX-1:0] word
);
  localparam int ACC_W = LANE_MAX + IN_MAX;
  localparam int CNT_W = $clog2(ACC_W + 1);
  localparam logic [CNT_W-1:0] WL_FULL = CNT_W'(LANE_MAX);
  localparam logic [CNT_W-1:0] WL_HALF = CNT_W'(LANE_MAX / 2);
  localparam logic [CNT_W-1:0] N_WIDE  = CNT_W'(IN_MAX);

  logic [ACC_W-1:0] acc;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] wl;
  logic [CNT_W-1:0] step;
  logic [ACC_W-1:0] new_bits;
  logic [ACC_W-1:0] shifted;
  logic [LANE_MAX-1:0] mask;

  always_comb begin
    wl       = narrow ? WL_HALF : WL_FULL;
    step     = wide_in ? N_WIDE : CNT_W'(1);
    new_bits = wide_in ? ACC_W'(bits) : ACC_W'(bits[0]);
    free     = (cnt < wl);
    shifted  = acc >> (cnt - wl);
    mask     = narrow ? LANE_MAX'((1 << (LANE_MAX / 2)) - 1) : '1;
    word     = shifted[LANE_MAX-1:0] & mask;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      acc <= '0;
      cnt <= '0;
    end else if (fire) begin
      acc <= (acc << step) | new_bits;
      cnt <= cnt + step;
    end else if (pop) begin
      cnt <= cnt - wl;
    end
  end
endmodule

// File: rtl/lcd_pix_packer.sv
module lcd_pix_packer
  import lcd_pack_pkg::*;
#(
  parameter int BUS_W    = 24,
  parameter int LANE_MAX = 8,
  parameter int SUB_BITS = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       cfg_disp,
  input  logic             cfg_dual,
  input  logic [1:0]       cfg_width,
  input  logic             up_valid,
  output logic             up_ready,
  input  logic [BUS_W-1:0] up_data,
  input  logic             lo_valid,
  output logic             lo_ready,
  input  logic [BUS_W-1:0] lo_data,
  output logic [BUS_W-1:0] lcd_data,
  output logic             lcd_strobe,
  output logic             cfg_err
);
  localparam int N_LANES = 2;
  localparam int CFG_W   = 5;

  cfg_dec_t         dec;
  logic [CFG_W-1:0] cfg_now, cfg_q;
  logic             cfg_chg;
  logic             run;
  logic             stn_go;
  logic             up_fire, lo_fire, pop;
  logic [N_LANES-1:0] lane_free;
  logic [N_LANES-1:0] lane_fire;
  logic [LANE_MAX-1:0] lane_word [N_LANES];
  logic [SUB_BITS-1:0] lane_bits [N_LANES];
  logic [BUS_W-1:0] packed_word;
  int unsigned      half_w;

  lcd_cfg_decode u_dec (
    .disp  (cfg_disp),
    .dual  (cfg_dual),
    .width (cfg_width),
    .dec   (dec)
  );

  assign cfg_now = {cfg_disp, cfg_dual, cfg_width};
  assign cfg_chg = (cfg_now != cfg_q);
  assign cfg_err = !dec.legal;
  assign run     = dec.legal && !cfg_chg;
  assign stn_go  = run && !dec.tft;

  always_ff @(posedge clk) begin
    if (!rst_n) cfg_q <= cfg_now;
    else        cfg_q <= cfg_now;
  end

  always_comb begin
    if (!run) begin
      up_ready = 1'b0;
      lo_ready = 1'b0;
    end else if (dec.tft) begin
      up_ready = 1'b1;
      lo_ready = 1'b0;
    end else if (dec.dual) begin
      up_ready = &lane_free && lo_valid;
      lo_ready = &lane_free && up_valid;
    end else begin
      up_ready = lane_free[0];
      lo_ready = 1'b0;
    end
  end

  assign up_fire = up_valid && up_ready;
  assign lo_fire = lo_valid && lo_ready;
  assign pop     = stn_go && !lane_free[0] && (!dec.dual || !lane_free[1]);

  assign lane_fire[0] = up_fire && !dec.tft;
  assign lane_fire[1] = lo_fire;
  assign lane_bits[0] = up_data[SUB_BITS-1:0];
  assign lane_bits[1] = lo_data[SUB_BITS-1:0];

  for (genvar g = 0; g < N_LANES; g++) begin : g_lane
    lcd_lane_packer #(
      .LANE_MAX (LANE_MAX),
      .IN_MAX   (SUB_BITS)
    ) u_lane (
      .clk     (clk),
      .rst_n   (rst_n),
      .flush   (cfg_chg || !dec.legal),
      .narrow  (dec.narrow),
      .wide_in (dec.color),
      .fire    (lane_fire[g]),
      .bits    (lane_bits[g]),
      .pop     (pop),
      .free    (lane_free[g]),
      .word    (lane_word[g])
    );
  end

  always_comb begin
    half_w = dec.narrow ? (LANE_MAX / 2) : LANE_MAX;
    if (dec.dual)
      packed_word = (BUS_W'(lane_word[0]) << half_w) | BUS_W'(lane_word[1]);
    else
      packed_word = BUS_W'(lane_word[0]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !dec.legal) begin
      lcd_data   <= '0;
      lcd_strobe <= 1'b0;
    end else if (dec.tft && up_fire) begin
      lcd_data   <= up_data;
      lcd_strobe <= 1'b1;
    end else if (pop) begin
      lcd_data   <= packed_word;
      lcd_strobe <= 1'b1;
    end else begin
      lcd_strobe <= 1'b0;
    end
  end
endmodule

// File: rtl/lcd_pix_packer_chk.sv
module lcd_pix_packer_chk #(
  parameter int BUS_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       cfg_disp,
  input logic             cfg_dual,
  input logic [1:0]       cfg_width,
  input logic             up_valid,
  input logic             up_ready,
  input logic [BUS_W-1:0] up_data,
  input logic             lo_valid,
  input logic             lo_ready,
  input logic [BUS_W-1:0] lcd_data,
  input logic             lcd_strobe,
  input logic             cfg_err
);
  logic ok_chk;
  always_comb begin
    case (cfg_disp)
      2'd0:    ok_chk = !cfg_dual;
      2'd1,
      2'd2:    ok_chk = (cfg_width == 2'd1) ||
                        (cfg_width == 2'd0 && !cfg_dual) ||
                        (cfg_width == 2'd2 && cfg_dual);
      default: ok_chk = 1'b0;
    endcase
  end

  AST_ERR_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err == !ok_chk);  // R1
  AST_ERR_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> (!up_ready && !lo_ready));  // R2
  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_err && $past(cfg_err)) |-> (lcd_data == '0 && !lcd_strobe));  // R2
  AST_STROBE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    lcd_strobe |-> !$past(cfg_err));  // R2
  AST_TFT_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_disp == 2'd0 && !cfg_dual && up_valid && up_ready)
      |=> (lcd_strobe && lcd_data == $past(up_data)));  // R3
  AST_STN_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
    (lcd_strobe && cfg_disp != 2'd0 && $stable(cfg_disp)) |-> (lcd_data[BUS_W-1:16] == '0));  // R4
  AST_LOCKSTEP: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_dual |-> ((up_valid && up_ready) == (lo_valid && lo_ready)));  // R7
  AST_LO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_dual |-> !lo_ready);  // R8
endmodule

bind lcd_pix_packer lcd_pix_packer_chk #(.BUS_W(BUS_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_disp   (cfg_disp),
  .cfg_dual   (cfg_dual),
  .cfg_width  (cfg_width),
  .up_valid   (up_valid),
  .up_ready   (up_ready),
  .up_data    (up_data),
  .lo_valid   (lo_valid),
  .lo_ready   (lo_ready),
  .lcd_data   (lcd_data),
  .lcd_strobe (lcd_strobe),
  .cfg_err    (cfg_err)
);

// File: tb/tb_lcd_pix_packer.sv
`timescale 1ns/1ps
module tb_lcd_pix_packer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cfg_disp = 2'd0;
  logic        cfg_dual = 1'b0;
  logic [1:0]  cfg_width = 2'd0;
  logic        up_valid = 1'b0, lo_valid = 1'b0;
  logic        up_ready, lo_ready;
  logic [23:0] up_data = '0, lo_data = '0;
  logic [23:0] lcd_data;
  logic        lcd_strobe, cfg_err;

  int n_tests = 0;
  int n_fail  = 0;
  logic [23:0] cap [64];
  int ncap = 0;
  int cur_base = 0;

  always #5 clk = ~clk;

  lcd_pix_packer dut (
    .clk(clk), .rst_n(rst_n), .cfg_disp(cfg_disp), .cfg_dual(cfg_dual),
    .cfg_width(cfg_width), .up_valid(up_valid), .up_ready(up_ready),
    .up_data(up_data), .lo_valid(lo_valid), .lo_ready(lo_ready),
    .lo_data(lo_data), .lcd_data(lcd_data), .lcd_strobe(lcd_strobe),
    .cfg_err(cfg_err)
  );

  always @(negedge clk) begin
    if (rst_n && lcd_strobe && ncap < 64) begin
      cap[ncap] = lcd_data;
      ncap++;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] up_pix(input int k);
    return 24'((k * 24'h1357B) ^ 24'hA5C3E1 ^ (k << 3));
  endfunction
  function automatic logic [23:0] lo_pix(input int k);
    return 24'((k * 24'h2E91D) ^ 24'h3C6A0F ^ (k >> 1));
  endfunction

  function automatic logic sbit(input bit lower, input int i, input int bpp, input int base);
    logic [23:0] d;
    d = lower ? lo_pix(base + i / bpp) : up_pix(base + i / bpp);
    return d[bpp - 1 - (i % bpp)];
  endfunction

  function automatic logic [23:0] exp_word(input int j, input int bpp, input int wl,
                                           input bit dual, input int base);
    logic [23:0] w = '0;
    for (int b = 0; b < wl; b++) begin
      if (dual) begin
        w[2*wl - 1 - b] = sbit(1'b0, j*wl + b, bpp, base);
        w[wl - 1 - b]   = sbit(1'b1, j*wl + b, bpp, base);
      end else begin
        w[wl - 1 - b] = sbit(1'b0, j*wl + b, bpp, base);
      end
    end
    return w;
  endfunction

  task automatic set_cfg(input logic [1:0] d, input logic du, input logic [1:0] w);
    @(negedge clk);
    cfg_disp = d; cfg_dual = du; cfg_width = w;
    repeat (3) @(negedge clk);
    ncap = 0;
  endtask

  // one transfer, starting and ending at a falling edge
  task automatic send(input int k, input bit dual, input bit skew);
    up_data = up_pix(k);
    lo_data = lo_pix(k);
    up_valid = 1'b1;
    lo_valid = dual && !skew;
    if (dual && skew) begin
      #1;
      check("R7 partner missing", {31'd0, up_ready}, 32'd0);
      @(negedge clk);
      lo_valid = 1'b1;
    end
    #1;
    while (!up_ready) begin
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    up_valid = 1'b0;
    lo_valid = 1'b0;
  endtask

  task automatic run_stream(input int n, input int base, input bit dual);
    for (int k = 0; k < n; k++) begin
      if (k % 5 == 3) @(negedge clk);
      send(base + k, dual, dual && (k % 4 == 1));
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic stn_case(input string req, input logic [1:0] d, input logic du,
                          input logic [1:0] w);
    int bpp, tot, wl, nw;
    bpp = (d == 2'd2) ? 3 : 1;
    tot = (w == 2'd0) ? 4 : (w == 2'd1) ? 8 : 16;
    wl  = du ? tot / 2 : tot;
    set_cfg(d, du, w);
    check({req, " R1 legal"}, {31'd0, cfg_err}, 32'd0);
    run_stream(24, 0, du);
    nw = (24 * bpp) / wl;
    check({req, " R9 word count"}, ncap, nw);
    for (int j = 0; j < nw && j < 64; j++)
      check(req, cap[j], exp_word(j, bpp, wl, du, 0));
  endtask

  task automatic err_case(input logic [1:0] d, input logic du, input logic [1:0] w);
    set_cfg(d, du, w);
    up_valid = 1'b1; lo_valid = 1'b1;
    #1;
    check("R1 illegal flagged", {31'd0, cfg_err}, 32'd1);
    check("R2 up stalled", {31'd0, up_ready}, 32'd0);
    check("R2 lo stalled", {31'd0, lo_ready}, 32'd0);
    repeat (3) @(negedge clk);
    check("R2 bus zero", lcd_data, 32'd0);
    check("R2 no strobe", ncap, 32'd0);
    up_valid = 1'b0; lo_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R3 reset data", lcd_data, 32'd0);
    check("R3 reset strobe", {31'd0, lcd_strobe}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    check("R3 tft ready", {31'd0, up_ready}, 32'd1);
    check("R8 lo idle single", {31'd0, lo_ready}, 32'd0);

    // R3 TFT pass-through with a lower stream that must be ignored (R8)
    set_cfg(2'd0, 1'b0, 2'd3);
    check("R1 tft ignores width", {31'd0, cfg_err}, 32'd0);
    lo_valid = 1'b1;
    for (int k = 0; k < 24; k++) begin
      up_data = up_pix(k); lo_data = lo_pix(k); up_valid = 1'b1;
      @(negedge clk);
    end
    up_valid = 1'b0; lo_valid = 1'b0;
    repeat (3) @(negedge clk);
    check("R9 tft count", ncap, 32'd24);
    for (int k = 0; k < 24; k++) check("R3 tft word", cap[k], up_pix(k));

    // STN sweeps: R4 mono, R5 colour, R6 dual
    stn_case("R4 mono s4",  2'd1, 1'b0, 2'd0);
    stn_case("R4 mono s8",  2'd1, 1'b0, 2'd1);
    stn_case("R6 mono d8",  2'd1, 1'b1, 2'd1);
    stn_case("R6 mono d16", 2'd1, 1'b1, 2'd2);
    stn_case("R5 color s4", 2'd2, 1'b0, 2'd0);
    stn_case("R5 color s8", 2'd2, 1'b0, 2'd1);
    stn_case("R6 color d8", 2'd2, 1'b1, 2'd1);
    stn_case("R6 color d16",2'd2, 1'b1, 2'd2);

    // R10 partial bits dropped on change, R11 back-pressure
    set_cfg(2'd1, 1'b0, 2'd1);
    run_stream(5, 200, 1'b0);
    check("R10 no word from 5 bits", ncap, 32'd0);
    set_cfg(2'd1, 1'b0, 2'd0);
    for (int k = 0; k < 4; k++) send(300 + k, 1'b0, 1'b0);
    #1;
    check("R11 ready low on full lane", {31'd0, up_ready}, 32'd0);
    @(negedge clk);
    check("R9 strobe after pop", {31'd0, lcd_strobe}, 32'd1);
    check("R10 fresh word", lcd_data, exp_word(0, 1, 4, 1'b0, 300));
    @(negedge clk);
    check("R9 strobe single cycle", {31'd0, lcd_strobe}, 32'd0);
    check("R10 one word", ncap, 32'd1);

    // R1/R2 illegal combinations
    err_case(2'd0, 1'b1, 2'd1);
    err_case(2'd3, 1'b0, 2'd1);
    err_case(2'd1, 1'b1, 2'd0);
    err_case(2'd2, 1'b0, 2'd2);
    err_case(2'd1, 1'b0, 2'd3);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule